// File: doc/BRIEF.md
# Protected-RAM Error Logger and Notifier

This block sits beside a protected RAM shared by four bus masters and turns the error events reported by the RAM's checking logic into logged addresses and notifications. Each event carries the requesting master, the kind of error, whether it arose in the read phase of a read-modify-write, the failing address and a debug flag. Uncorrectable data errors and address errors go to the notification that belongs to the requester. CPU-B and DMA-B get a non-maskable interrupt. CPU-A gets a bus fault. DMA-A gets an ordinary interrupt.

Single-bit corrected errors do not interrupt on each event. They are counted, and one interrupt is raised when the count reaches a threshold that software programs. Each master has its own read-error address log, and one more log serves read-modify-write errors. Every log keeps the first failing address until software clears it. A later capture into a full log only sets a sticky overflow bit.

Software reads the logs, the status, the counter and the threshold through a small register port. Writing the status address clears flags.

Top module: `memerr_log`

## Requirements
- R1: An uncorrectable read event (errKind 1 = parity/double-bit, 2 = address error, 3 = treated as fatal too) stores errAddr in the read log of the requester. Read logs sit at register addresses 0..3, indexed by errMaster (0 CPU-A, 1 DMA-A, 2 CPU-B, 3 DMA-B). It also sets that log's valid bit, which is status bit [master].
- R2: A fatal read event from CPU-B or DMA-B makes nmiPulse high for exactly the one cycle after the event's clock edge.
- R3: A fatal read or write event from CPU-A makes busFaultPulse high for exactly the one cycle after the event's clock edge.
- R4: A fatal read or write event from DMA-A sets dmaAIrq on the next edge. The level holds until a write to register 5 with bit 16 set.
- R5: A fatal event with errWrite=1 stores errAddr in the write log (register 4, status valid bit 4), whichever master caused it. CPU-B and DMA-B write events raise no notification. A single-bit event with errWrite=1 has no effect at all.
- R6: A single-bit read event (errKind 0) is logged like R1 and increments the counter at register 6. The counter saturates at 2^CNT_W-1.
- R7: thrIrq is set when an increment changes the counter to a value equal to a non-zero threshold. The threshold is the value at register 7 before any write in the same cycle. thrIrq holds until a write to register 5 with bit 17 set, which also zeroes the counter. An increment in that same cycle then counts from zero.
- R8: A log that is already valid keeps its address when another event arrives, and its overflow bit (status bit 5+index) sets. A write to register 5 with bit i set clears valid and overflow of log i. An event arriving in that same cycle is captured into the freshly cleared log.
- R9: Events with errDebug=1 change no log, counter or output.
- R10: After reset all registers read zero and all four notification outputs are low. Status layout: valid bits 4:0, overflow bits 9:5, dmaAIrq bit 16, thrIrq bit 17. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | An error event is present this cycle |
| errDebug | input | 1 | Event came from a debug access |
| errWrite | input | 1 | Event came from a read-modify-write |
| errMaster | input | 2 | Requester: 0 CPU-A, 1 DMA-A, 2 CPU-B, 3 DMA-B |
| errKind | input | 2 | 0 single-bit, nonzero fatal |
| errAddr | input | ADDR_W | Failing address |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register write address |
| regWrData | input | DATA_W | Register write data |
| regRdAddr | input | 4 | Register read address |
| regRdData | output | DATA_W | Register read data (combinational) |
| nmiPulse | output | 1 | Non-maskable interrupt pulse |
| busFaultPulse | output | 1 | Bus fault pulse to CPU-A |
| dmaAIrq | output | 1 | Level interrupt to DMA-A |
| thrIrq | output | 1 | Single-error threshold interrupt |

## Verification
A wrong valid or overflow bit shows in the status word on the cycle right after the event edge. It also shows later as a log that fails to hold, or fails to take, the next address. A counter that stays at its limit badly, or steps past it, shows up at register 6. It also shows as a thrIrq edge one increment early or late. A misrouted event shows within one cycle: the pulse or level appears on the wrong notification output.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  typedef enum logic [1:0] {
    M_CPU_A = 2'd0,
    M_DMA_A = 2'd1,
    M_CPU_B = 2'd2,
    M_DMA_B = 2'd3
  } master_e;

  localparam int NUM_MASTERS = 4;
  localparam int NUM_LOGS    = NUM_MASTERS + 1;
  localparam int WR_LOG      = NUM_MASTERS;

  localparam logic [3:0] REG_STATUS = 4'd5;
  localparam logic [3:0] REG_COUNT  = 4'd6;
  localparam logic [3:0] REG_THRESH = 4'd7;

  localparam int ST_OVF_LSB = NUM_LOGS;
  localparam int ST_DMA_IRQ = 16;
  localparam int ST_THR_IRQ = 17;

  typedef struct packed {
    logic [NUM_LOGS-1:0] capture;
    logic [NUM_LOGS-1:0] clear;
    logic                incCount;
    logic                clrCount;
    logic                loadThresh;
  } strobe_t;
endpackage

// File: rtl/memerr_ctrl.sv
module memerr_ctrl
  import memerr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic              errDebug,
  input  logic              errWrite,
  input  logic [1:0]        errMaster,
  input  logic [1:0]        errKind,
  input  logic              regWrEn,
  input  logic [3:0]        regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              hitThresh,
  output strobe_t           strb,
  output logic              nmiPulse,
  output logic              busFaultPulse,
  output logic              dmaAIrq,
  output logic              thrIrq
);
  logic live, fatal, single, clrWr;

  always_comb begin
    live   = errValid && !errDebug;
    fatal  = live && (errKind != 2'd0);
    single = live && (errKind == 2'd0) && !errWrite;
    clrWr  = regWrEn && (regWrAddr == REG_STATUS);

    strb = '0;
    if (fatal || single) begin
      if (errWrite) strb.capture[WR_LOG] = 1'b1;
      else          strb.capture[errMaster] = 1'b1;
    end
    if (clrWr) strb.clear = regWrData[NUM_LOGS-1:0];
    strb.incCount   = single;
    strb.clrCount   = clrWr && regWrData[ST_THR_IRQ];
    strb.loadThresh = regWrEn && (regWrAddr == REG_THRESH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPulse      <= 1'b0;
      busFaultPulse <= 1'b0;
      dmaAIrq       <= 1'b0;
      thrIrq        <= 1'b0;
    end else begin
      nmiPulse      <= fatal && !errWrite &&
                       ((errMaster == M_CPU_B) || (errMaster == M_DMA_B));
      busFaultPulse <= fatal && (errMaster == M_CPU_A);
      dmaAIrq       <= (dmaAIrq && !(clrWr && regWrData[ST_DMA_IRQ])) ||
                       (fatal && (errMaster == M_DMA_A));
      thrIrq        <= (thrIrq && !strb.clrCount) || (single && hitThresh);
    end
  end
endmodule

// File: rtl/memerr_dp.sv
module memerr_dp
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [3:0]        regRdAddr,
  input  logic              dmaAIrq,
  input  logic              thrIrq,
  output logic              hitThresh,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0]   logAddr [NUM_LOGS];
  logic [NUM_LOGS-1:0] logValid;
  logic [NUM_LOGS-1:0] logOvf;
  logic [CNT_W-1:0]    thresh;
  logic [CNT_W-1:0]    cntBase, cntNext;

  for (genvar i = 0; i < NUM_LOGS; i++) begin : g_log
    logic [ADDR_W-1:0] addrQ;
    logic              validQ, ovfQ;
    logic              baseValid, baseOvf;

    always_comb begin
      baseValid = validQ && !strb.clear[i];
      baseOvf   = ovfQ && !strb.clear[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ  <= '0;
        validQ <= 1'b0;
        ovfQ   <= 1'b0;
      end else if (strb.capture[i]) begin
        if (baseValid) begin
          validQ <= 1'b1;
          ovfQ   <= 1'b1;
        end else begin
          addrQ  <= errAddr;
          validQ <= 1'b1;
          ovfQ   <= baseOvf;
        end
      end else begin
        validQ <= baseValid;
        ovfQ   <= baseOvf;
      end
    end

    assign logAddr[i]  = addrQ;
    assign logValid[i] = validQ;
    assign logOvf[i]   = ovfQ;
  end

  always_comb begin
    cntBase   = strb.clrCount ? '0 : count;
    cntNext   = (strb.incCount && (cntBase != CNT_MAX)) ? cntBase + 1'b1 : cntBase;
    hitThresh = strb.incCount && (cntNext != cntBase) &&
                (thresh != '0) && (cntNext == thresh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      thresh <= '0;
    end else begin
      count <= cntNext;
      if (strb.loadThresh) thresh <= regWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_LOGS; i++) begin
      if (regRdAddr == 4'(i)) regRdData[ADDR_W-1:0] = logAddr[i];
    end
    case (regRdAddr)
      REG_STATUS: begin
        regRdData[NUM_LOGS-1:0]                   = logValid;
        regRdData[ST_OVF_LSB +: NUM_LOGS]         = logOvf;
        regRdData[ST_DMA_IRQ]                     = dmaAIrq;
        regRdData[ST_THR_IRQ]                     = thrIrq;
      end
      REG_COUNT:  regRdData[CNT_W-1:0] = count;
      REG_THRESH: regRdData[CNT_W-1:0] = thresh;
      default: ;
    endcase
  end
endmodule

// File: rtl/memerr_log.sv
module memerr_log
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic              errDebug,
  input  logic              errWrite,
  input  logic [1:0]        errMaster,
  input  logic [1:0]        errKind,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              regWrEn,
  input  logic [3:0]        regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [3:0]        regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              nmiPulse,
  output logic              busFaultPulse,
  output logic              dmaAIrq,
  output logic              thrIrq
);
  strobe_t          strb;
  logic             hitThresh;
  logic [CNT_W-1:0] count;

  memerr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .errValid(errValid), .errDebug(errDebug), .errWrite(errWrite),
    .errMaster(errMaster), .errKind(errKind),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .hitThresh(hitThresh), .strb(strb),
    .nmiPulse(nmiPulse), .busFaultPulse(busFaultPulse),
    .dmaAIrq(dmaAIrq), .thrIrq(thrIrq)
  );

  memerr_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errAddr(errAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr),
    .dmaAIrq(dmaAIrq), .thrIrq(thrIrq),
    .hitThresh(hitThresh), .count(count), .regRdData(regRdData)
  );
endmodule

// File: rtl/memerr_log_chk.sv
module memerr_log_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              errValid,
  input logic              errDebug,
  input logic              errWrite,
  input logic [1:0]        errMaster,
  input logic [1:0]        errKind,
  input logic              regWrEn,
  input logic [3:0]        regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              nmiPulse,
  input logic              busFaultPulse,
  input logic              dmaAIrq,
  input logic              thrIrq,
  input logic [CNT_W-1:0]  count
);
  a_r2_nmi_source: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |-> $past(errValid && !errDebug && !errWrite && errKind != 2'd0 && errMaster[1]));

  a_r3_bus_fault_source: assert property (@(posedge clk) disable iff (!rstN)
    busFaultPulse |-> $past(errValid && !errDebug && errKind != 2'd0 && errMaster == 2'd0));

  a_r4_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dmaAIrq) && !$past(regWrEn && regWrAddr == 4'd5 && regWrData[16])) |-> dmaAIrq);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rstN)
    ((&$past(count)) && !$past(regWrEn && regWrAddr == 4'd5 && regWrData[17])) |-> (&count));

  a_r7_thr_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thrIrq) |-> $past(errValid && !errDebug && !errWrite && errKind == 2'd0));

  a_r9_debug_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(errValid && errDebug) |-> (!nmiPulse && !busFaultPulse));
endmodule

bind memerr_log memerr_log_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .errValid(errValid), .errDebug(errDebug),
  .errWrite(errWrite), .errMaster(errMaster), .errKind(errKind),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
  .nmiPulse(nmiPulse), .busFaultPulse(busFaultPulse),
  .dmaAIrq(dmaAIrq), .thrIrq(thrIrq), .count(count)
);

// File: tb/memerr_log_test.sv
module memerr_log_test;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errValid = 0, errDebug = 0, errWrite = 0;
  logic [1:0] errMaster = 0, errKind = 0;
  logic [ADDR_W-1:0] errAddr = 0;
  logic regWrEn = 0;
  logic [3:0] regWrAddr = 0, regRdAddr = 0;
  logic [DATA_W-1:0] regWrData = 0;
  logic [DATA_W-1:0] regRdData;
  logic nmiPulse, busFaultPulse, dmaAIrq, thrIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  memerr_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errDebug(errDebug),
    .errWrite(errWrite), .errMaster(errMaster), .errKind(errKind),
    .errAddr(errAddr), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .nmiPulse(nmiPulse), .busFaultPulse(busFaultPulse),
    .dmaAIrq(dmaAIrq), .thrIrq(thrIrq)
  );

  int tests = 0, fails = 0;

  // reference model state
  logic [ADDR_W-1:0] mAddr [5];
  logic [4:0] mValid = 0, mOvf = 0;
  logic [CNT_W-1:0] mCnt = 0, mThr = 0;
  logic mDma = 0, mThrIrq = 0, eNmi = 0, eBf = 0;

  function automatic logic [DATA_W-1:0] expRead(input logic [3:0] a);
    logic [DATA_W-1:0] r = '0;
    if (a < 4'd5) r[ADDR_W-1:0] = mAddr[a];
    else if (a == 4'd5) r = {14'b0, mThrIrq, mDma, 6'b0, mOvf, mValid};
    else if (a == 4'd6) r[CNT_W-1:0] = mCnt;
    else if (a == 4'd7) r[CNT_W-1:0] = mThr;
    return r;
  endfunction

  function automatic string readTag(input logic [3:0] a);
    if (a < 4'd4) return "R1";
    if (a == 4'd4) return "R5";
    if (a == 4'd5) return "R8";
    if (a == 4'd6) return "R6";
    return "R7";
  endfunction

  task automatic modelStep();
    logic live, fatal, single, clrWr;
    logic [CNT_W-1:0] oldThr;
    int idx;
    live   = errValid && !errDebug;
    fatal  = live && errKind != 2'd0;
    single = live && errKind == 2'd0 && !errWrite;
    clrWr  = regWrEn && regWrAddr == 4'd5;
    oldThr = mThr;
    if (clrWr) begin
      mValid = mValid & ~regWrData[4:0];
      mOvf   = mOvf & ~regWrData[4:0];
    end
    if (fatal || single) begin
      idx = errWrite ? 4 : int'(errMaster);
      if (mValid[idx]) mOvf[idx] = 1'b1;
      else begin mAddr[idx] = errAddr; mValid[idx] = 1'b1; end
    end
    eNmi = fatal && !errWrite && errMaster[1];
    eBf  = fatal && errMaster == 2'd0;
    if (clrWr && regWrData[16]) mDma = 1'b0;
    if (fatal && errMaster == 2'd1) mDma = 1'b1;
    if (clrWr && regWrData[17]) begin mCnt = '0; mThrIrq = 1'b0; end
    if (single && mCnt != CMAX) begin
      mCnt = mCnt + 1'b1;
      if (oldThr != '0 && mCnt == oldThr) mThrIrq = 1'b1;
    end
    if (regWrEn && regWrAddr == 4'd7) mThr = regWrData[CNT_W-1:0];
  endtask

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock with the given stimulus; compare everything after the edge
  task automatic step(input logic ev, input logic dbg, input logic wr,
                      input logic [1:0] m, input logic [1:0] k,
                      input logic [ADDR_W-1:0] a, input logic we,
                      input logic [3:0] wa, input logic [DATA_W-1:0] wd,
                      input logic [3:0] ra);
    @(negedge clk);
    errValid = ev; errDebug = dbg; errWrite = wr; errMaster = m; errKind = k;
    errAddr = a; regWrEn = we; regWrAddr = wa; regWrData = wd; regRdAddr = ra;
    modelStep();
    @(posedge clk);
    #1;
    check(dbg ? "R9" : "R2", "nmiPulse", 32'(nmiPulse), 32'(eNmi));
    check(dbg ? "R9" : "R3", "busFaultPulse", 32'(busFaultPulse), 32'(eBf));
    check("R4", "dmaAIrq", 32'(dmaAIrq), 32'(mDma));
    check("R7", "thrIrq", 32'(thrIrq), 32'(mThrIrq));
    check(readTag(ra), "regRdData", regRdData, expRead(ra));
  endtask

  task automatic idle(input logic [3:0] ra);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  task automatic clearAll();
    step(0, 0, 0, 0, 0, 0, 1, 4'd5, 32'h0003_001F, 4'd5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 5; i++) mAddr[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    for (int a = 0; a < 9; a++) begin
      regRdAddr = 4'(a);
      #1;
      check("R10", "reset read", regRdData, 32'h0);
    end
    check("R10", "reset outputs", {28'b0, nmiPulse, busFaultPulse, dmaAIrq, thrIrq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: fatal read from CPU-B, pulse one cycle then low
    step(1, 0, 0, 2'd2, 2'd1, 16'h1234, 0, 0, 0, 4'd2);
    idle(4'd5);
    // R2 / R1: address error from DMA-B
    step(1, 0, 0, 2'd3, 2'd2, 16'hBEEF, 0, 0, 0, 4'd3);
    idle(4'd3);
    // R3: CPU-A read and write fatal
    step(1, 0, 0, 2'd0, 2'd1, 16'h0AA0, 0, 0, 0, 4'd0);
    step(1, 0, 1, 2'd0, 2'd1, 16'h0BB0, 0, 0, 0, 4'd4);
    idle(4'd5);
    // R4: DMA-A holds until bit 16 cleared
    step(1, 0, 0, 2'd1, 2'd1, 16'h5555, 0, 0, 0, 4'd1);
    idle(4'd5); idle(4'd5);
    step(0, 0, 0, 0, 0, 0, 1, 4'd5, 32'h0001_0000, 4'd5);
    // R5: B-side write error logs, no notification; single write ignored
    clearAll();
    step(1, 0, 1, 2'd3, 2'd1, 16'h7777, 0, 0, 0, 4'd4);
    step(1, 0, 1, 2'd2, 2'd0, 16'h9999, 0, 0, 0, 4'd6);
    idle(4'd5);
    // R8: overflow on second capture, then clear + capture same cycle
    step(1, 0, 0, 2'd2, 2'd1, 16'h2222, 0, 0, 0, 4'd2);
    step(1, 0, 0, 2'd2, 2'd1, 16'h3333, 0, 0, 0, 4'd5);
    step(1, 0, 0, 2'd2, 2'd1, 16'h4444, 1, 4'd5, 32'h0000_0004, 4'd2);
    idle(4'd5);
    // R9: debug events ignored
    clearAll();
    step(1, 1, 0, 2'd2, 2'd1, 16'h6666, 0, 0, 0, 4'd2);
    step(1, 1, 0, 2'd1, 2'd0, 16'h6666, 0, 0, 0, 4'd6);
    idle(4'd5);
    // R7: threshold 3 hit exactly
    step(0, 0, 0, 0, 0, 0, 1, 4'd7, 32'd3, 4'd7);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 2'd0, 2'd0, 16'(i), 0, 0, 0, 4'd6);
    idle(4'd5);
    // R6: saturation with threshold disabled
    step(0, 0, 0, 0, 0, 0, 1, 4'd7, 32'd0, 4'd7);
    clearAll();
    for (int i = 0; i < 260; i++) step(1, 0, 0, 2'd1, 2'd0, 16'(i), 0, 0, 0, 4'd6);
    // R7: clear and increment in the same cycle
    step(0, 0, 0, 0, 0, 0, 1, 4'd7, 32'd1, 4'd7);
    step(1, 0, 0, 2'd3, 2'd0, 16'h0101, 1, 4'd5, 32'h0002_0000, 4'd6);
    idle(4'd5);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [3:0] wa;
      logic [DATA_W-1:0] wd;
      we = ($urandom % 10) == 0;
      wa = ($urandom % 2) ? 4'd5 : 4'd7;
      wd = (wa == 4'd7) ? 32'(1 + $urandom % 8) : $urandom;
      step(($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 5) == 0,
           2'($urandom), 2'($urandom), 16'($urandom),
           we, wa, wd, 4'($urandom % 9));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule